// File: doc/BRIEF.md
# Two-Core Snooping Coherence Controller

This block keeps two private caches coherent on a shared snooping bus using the three-state Modified/Shared/Invalid protocol. Each core presents requests made of a read or write flag, a line index, a tag and a one-word write value. The controller keeps a direct-mapped tag store per core. Each entry holds a tag, one data word and a two-bit coherence state. Requests from the two cores share one arbiter, and exactly one transaction completes in any cycle.

For the granted request the controller looks up both cores' entries at that index. A hit is answered locally. When the peer must be told, the controller sends a read and/or invalidate message on the bus. A line that the peer holds in Modified is supplied cache-to-cache instead of from memory, and on a peer read the owner's value is also written back. The memory read port and two write lanes are driven in the acceptance cycle, against a memory that answers in the same cycle. The response to the core follows one cycle later.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: Coherence states are stored as two bits with Invalid = 2'b00, Shared = 2'b01 and Modified = 2'b10. Reset leaves every line of both cores Invalid, so the first access to any address misses.
- R2: `req_ready` grants at most one core per cycle and only a requesting core. When both cores request, the grant goes to the core not granted most recently. After reset core 0 wins the first contest.
- R3: The memory ports (`mem_rd_en`, `mem_wr_en` and their address and data) are valid in the acceptance cycle. `rsp_valid`, `rsp_core`, `rsp_hit`, `rsp_c2c`, `rsp_bus` and `rsp_rdata` are valid exactly one cycle after acceptance.
- R4: A read whose tag matches a Shared or Modified local entry is a hit. It gives `rsp_hit`=1 and `rsp_bus`=0, causes no memory access, and returns the local word.
- R5: A write that hits a Modified local entry gives `rsp_hit`=1 and `rsp_bus`=0, causes no memory access, and stores the new word.
- R6: A write that hits a Shared local entry gives `rsp_hit`=1 and sends an invalidate (`rsp_bus` = 2'b10). A matching peer copy becomes Invalid, the local entry becomes Modified, and memory is not read.
- R7: A read miss whose peer does not hold the address in Modified sends a read message (`rsp_bus` = 2'b01). It fetches from memory at address {tag, index}, returns `mem_rdata`, and leaves the local entry Shared.
- R8: A read miss whose peer holds the address in Modified sends a read message and sets `rsp_c2c`. It returns the peer's word without a memory read and writes that word back on lane 1 to address {tag, index}. Both copies end Shared.
- R9: A write miss sends read and invalidate together (`rsp_bus` = 2'b11) and never reads memory. A matching peer copy becomes Invalid, and `rsp_c2c` is set when that copy was Modified. The local entry becomes Modified with the write value, and `rsp_rdata` echoes it.
- R10: A miss that replaces a Modified local entry of another tag writes the old word back on lane 0 to address {old tag, index}.
- R11: For every index where both cores hold a valid copy of the same tag, the pair is Shared/Shared. Modified never coexists with another valid copy.
- R12: `err_state` rises whenever any stored state equals the unused code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 2 | Request valid, bit c for core c |
| req_write | input | 2 | 1 = write, 0 = read, per core |
| req_index | input | 2*IDX_W | Line index, core c in slice c |
| req_tag | input | 2*TAG_W | Tag, core c in slice c |
| req_wdata | input | 2*DATA_W | Write word, core c in slice c |
| req_ready | output | 2 | One-hot acceptance for this cycle |
| mem_rd_en | output | 1 | Memory fetch for the accepted request |
| mem_rd_addr | output | TAG_W+IDX_W | Fetch address {tag, index} |
| mem_rdata | input | DATA_W | Fetched word, same cycle |
| mem_wr_en | output | 2 | Lane 0 eviction write-back, lane 1 sharing write-back |
| mem_wr_addr | output | 2*(TAG_W+IDX_W) | Write-back address per lane |
| mem_wr_data | output | 2*DATA_W | Write-back word per lane |
| rsp_valid | output | 1 | Response valid |
| rsp_core | output | 1 | Core the response belongs to |
| rsp_hit | output | 1 | Request hit locally |
| rsp_c2c | output | 1 | Peer supplied the line cache-to-cache |
| rsp_bus | output | 2 | Bus messages sent: bit 0 read, bit 1 invalidate |
| rsp_rdata | output | DATA_W | Line value after the access |
| err_state | output | 1 | Unused state code present in a store |

## Verification
Memory control is combinational from the granted request. The bench therefore drives a request just after a falling edge and samples `req_ready` and the memory ports one nanosecond later, before the rising edge that accepts the request. Response fields are registered at that rising edge, so they are checked at the following falling edge. At the same point the request is withdrawn, so each request is taken exactly once. When both cores contend, the loser's request stays up, and its grant and memory ports are checked in the next cycle, followed by its response one cycle after that.

// File: rtl/msi_pkg.sv
package msi_pkg;
   typedef enum logic [1:0] {
      ST_I = 2'b00,
      ST_S = 2'b01,
      ST_M = 2'b10
   } msi_state_e;

   localparam int BUS_RD_BIT  = 0;
   localparam int BUS_INV_BIT = 1;
endpackage

// File: rtl/msi_rr_arb.sv
module msi_rr_arb (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] req,
   output logic [1:0] gnt,
   output logic       sel
);
   logic last_q;

   always_comb begin
      if (req == 2'b11) sel = ~last_q;
      else              sel = req[1];
      gnt = 2'b00;
      if (|req) gnt[sel] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     last_q <= 1'b1;
      else if (|req)  last_q <= sel;
   end
endmodule

// File: rtl/msi_line_store.sv
module msi_line_store #(
   parameter int IDX_W  = 3,
   parameter int TAG_W  = 4,
   parameter int DATA_W = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [IDX_W-1:0]              rd_idx,
   output logic [1:0]                    rd_st,
   output logic [TAG_W-1:0]              rd_tag,
   output logic [DATA_W-1:0]             rd_data,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [1:0]                    wr_st,
   input  logic [TAG_W-1:0]              wr_tag,
   input  logic [DATA_W-1:0]             wr_data,
   output logic [(1<<IDX_W)*2-1:0]       st_flat,
   output logic [(1<<IDX_W)*TAG_W-1:0]   tag_flat,
   output logic                          bad
);
   localparam int LINES = 1 << IDX_W;

   logic [LINES-1:0][1:0]        st_q;
   logic [LINES-1:0][TAG_W-1:0]  tag_q;
   logic [LINES-1:0][DATA_W-1:0] data_q;
   logic [LINES-1:0]             line_bad;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= '0;
         tag_q  <= '0;
         data_q <= '0;
      end else if (wr_en) begin
         st_q[wr_idx]   <= wr_st;
         tag_q[wr_idx]  <= wr_tag;
         data_q[wr_idx] <= wr_data;
      end
   end

   assign rd_st    = st_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_data  = data_q[rd_idx];
   assign st_flat  = st_q;
   assign tag_flat = tag_q;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      assign line_bad[g] = &st_q[g];
   end
   assign bad = |line_bad;
endmodule

// File: rtl/msi_xact.sv
module msi_xact
   import msi_pkg::*;
#(
   parameter int IDX_W  = 3,
   parameter int TAG_W  = 4,
   parameter int DATA_W = 16
) (
   input  logic                    is_wr,
   input  logic [IDX_W-1:0]        idx,
   input  logic [TAG_W-1:0]        tag,
   input  logic [DATA_W-1:0]       wdata,
   input  logic [1:0]              own_st,
   input  logic [TAG_W-1:0]        own_tag,
   input  logic [DATA_W-1:0]       own_data,
   input  logic [1:0]              peer_st,
   input  logic [TAG_W-1:0]        peer_tag,
   input  logic [DATA_W-1:0]       peer_data,
   input  logic [DATA_W-1:0]       mem_rdata,
   output logic                    hit,
   output logic                    c2c,
   output logic [1:0]              bus,
   output logic                    fetch,
   output logic                    evict,
   output logic [TAG_W+IDX_W-1:0]  evict_addr,
   output logic                    share_wb,
   output logic [1:0]              own_st_n,
   output logic [DATA_W-1:0]       own_data_n,
   output logic                    peer_upd,
   output logic [1:0]              peer_st_n,
   output logic [DATA_W-1:0]       rdata
);
   logic own_match, peer_match, peer_owns;

   assign own_match  = (own_st != ST_I)  && (own_tag == tag);
   assign peer_match = (peer_st != ST_I) && (peer_tag == tag);
   assign peer_owns  = peer_match && (peer_st == ST_M);
   assign evict      = !own_match && (own_st == ST_M);
   assign evict_addr = {own_tag, idx};

   always_comb begin
      hit        = own_match;
      c2c        = 1'b0;
      bus        = 2'b00;
      fetch      = 1'b0;
      share_wb   = 1'b0;
      own_st_n   = own_st;
      own_data_n = own_data;
      peer_upd   = 1'b0;
      peer_st_n  = peer_st;
      rdata      = own_data;
      if (!is_wr) begin
         if (!own_match) begin
            bus[BUS_RD_BIT] = 1'b1;
            own_st_n        = ST_S;
            if (peer_owns) begin
               c2c       = 1'b1;
               share_wb  = 1'b1;
               peer_upd  = 1'b1;
               peer_st_n = ST_S;
               rdata     = peer_data;
            end else begin
               fetch = 1'b1;
               rdata = mem_rdata;
            end
            own_data_n = rdata;
         end
      end else begin
         rdata      = wdata;
         own_data_n = wdata;
         own_st_n   = ST_M;
         if (!own_match) begin
            bus = 2'b11;
            c2c = peer_owns;
         end else if (own_st == ST_S) begin
            bus[BUS_INV_BIT] = 1'b1;
         end
         if (peer_match) begin
            peer_upd  = 1'b1;
            peer_st_n = ST_I;
         end
      end
   end
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
   import msi_pkg::*;
#(
   parameter int IDX_W  = 3,
   parameter int TAG_W  = 4,
   parameter int DATA_W = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [1:0]                    req_valid,
   input  logic [1:0]                    req_write,
   input  logic [2*IDX_W-1:0]            req_index,
   input  logic [2*TAG_W-1:0]            req_tag,
   input  logic [2*DATA_W-1:0]           req_wdata,
   output logic [1:0]                    req_ready,
   output logic                          mem_rd_en,
   output logic [TAG_W+IDX_W-1:0]        mem_rd_addr,
   input  logic [DATA_W-1:0]             mem_rdata,
   output logic [1:0]                    mem_wr_en,
   output logic [2*(TAG_W+IDX_W)-1:0]    mem_wr_addr,
   output logic [2*DATA_W-1:0]           mem_wr_data,
   output logic                          rsp_valid,
   output logic                          rsp_core,
   output logic                          rsp_hit,
   output logic                          rsp_c2c,
   output logic [1:0]                    rsp_bus,
   output logic [DATA_W-1:0]             rsp_rdata,
   output logic                          err_state
);
   localparam int ADDR_W = TAG_W + IDX_W;
   localparam int LINES  = 1 << IDX_W;

   if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
      $error("IDX_W must lie in 1..12");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("TAG_W must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end

   logic                         sel, accept;
   logic [1:0][IDX_W-1:0]        idx_v;
   logic [1:0][TAG_W-1:0]        tag_v;
   logic [1:0][DATA_W-1:0]       wd_v;
   logic [1:0][1:0]              c_st;
   logic [1:0][TAG_W-1:0]        c_tag;
   logic [1:0][DATA_W-1:0]       c_data;
   logic [1:0][2*LINES-1:0]      st_all;
   logic [1:0][TAG_W*LINES-1:0]  tag_all;
   logic [1:0]                   bad;

   logic                         x_hit, x_c2c, x_fetch, x_evict, x_share, x_peer_upd;
   logic [1:0]                   x_bus, x_own_st, x_peer_st;
   logic [ADDR_W-1:0]            x_evict_addr;
   logic [DATA_W-1:0]            x_own_data, x_rdata;

   assign idx_v = req_index;
   assign tag_v = req_tag;
   assign wd_v  = req_wdata;

   msi_rr_arb arb_i (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_valid),
      .gnt   (req_ready),
      .sel   (sel)
   );
   assign accept = |req_ready;

   for (genvar c = 0; c < 2; c++) begin : g_core
      logic              is_req;
      logic              wr_en;
      logic [1:0]        wr_st;
      logic [TAG_W-1:0]  wr_tag;
      logic [DATA_W-1:0] wr_data;

      assign is_req  = (sel == c[0]);
      assign wr_en   = accept && (is_req || x_peer_upd);
      assign wr_st   = is_req ? x_own_st   : x_peer_st;
      assign wr_tag  = is_req ? tag_v[sel] : c_tag[c];
      assign wr_data = is_req ? x_own_data : c_data[c];

      msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .rd_idx   (idx_v[sel]),
         .rd_st    (c_st[c]),
         .rd_tag   (c_tag[c]),
         .rd_data  (c_data[c]),
         .wr_en    (wr_en),
         .wr_idx   (idx_v[sel]),
         .wr_st    (wr_st),
         .wr_tag   (wr_tag),
         .wr_data  (wr_data),
         .st_flat  (st_all[c]),
         .tag_flat (tag_all[c]),
         .bad      (bad[c])
      );
   end

   msi_xact #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) xact_i (
      .is_wr      (req_write[sel]),
      .idx        (idx_v[sel]),
      .tag        (tag_v[sel]),
      .wdata      (wd_v[sel]),
      .own_st     (c_st[sel]),
      .own_tag    (c_tag[sel]),
      .own_data   (c_data[sel]),
      .peer_st    (c_st[~sel]),
      .peer_tag   (c_tag[~sel]),
      .peer_data  (c_data[~sel]),
      .mem_rdata  (mem_rdata),
      .hit        (x_hit),
      .c2c        (x_c2c),
      .bus        (x_bus),
      .fetch      (x_fetch),
      .evict      (x_evict),
      .evict_addr (x_evict_addr),
      .share_wb   (x_share),
      .own_st_n   (x_own_st),
      .own_data_n (x_own_data),
      .peer_upd   (x_peer_upd),
      .peer_st_n  (x_peer_st),
      .rdata      (x_rdata)
   );

   assign mem_rd_en   = accept && x_fetch;
   assign mem_rd_addr = {tag_v[sel], idx_v[sel]};
   assign mem_wr_en   = {accept && x_share, accept && x_evict};
   assign mem_wr_addr = {tag_v[sel], idx_v[sel], x_evict_addr};
   assign mem_wr_data = {c_data[~sel], c_data[sel]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_core  <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_c2c   <= 1'b0;
         rsp_bus   <= 2'b00;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= accept;
         if (accept) begin
            rsp_core  <= sel;
            rsp_hit   <= x_hit;
            rsp_c2c   <= x_c2c;
            rsp_bus   <= x_bus;
            rsp_rdata <= x_rdata;
         end
      end
   end

   assign err_state = |bad;
endmodule

// File: rtl/msi_snoop_chk.sv
module msi_snoop_chk #(
   parameter int IDX_W = 3,
   parameter int TAG_W = 4
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic [1:0]                        req_valid,
   input logic [1:0]                        req_ready,
   input logic                              mem_rd_en,
   input logic [1:0]                        mem_wr_en,
   input logic                              rsp_valid,
   input logic                              rsp_hit,
   input logic                              rsp_c2c,
   input logic [1:0]                        rsp_bus,
   input logic [1:0][2*(1<<IDX_W)-1:0]      st_all,
   input logic [1:0][TAG_W*(1<<IDX_W)-1:0]  tag_all,
   input logic                              err_state
);
   localparam int LINES = 1 << IDX_W;

   logic pair_bad;
   always_comb begin
      pair_bad = 1'b0;
      for (int i = 0; i < LINES; i++) begin
         if (st_all[0][2*i +: 2] != 2'b00 && st_all[1][2*i +: 2] != 2'b00 &&
             tag_all[0][TAG_W*i +: TAG_W] == tag_all[1][TAG_W*i +: TAG_W] &&
             (st_all[0][2*i +: 2] != 2'b01 || st_all[1][2*i +: 2] != 2'b01))
            pair_bad = 1'b1;
      end
   end

   assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_ready) && ((req_ready & ~req_valid) == 2'b00));

   assert_alternate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (&req_valid && $past(&req_valid && req_ready[0])) |-> req_ready[1]);

   assert_rsp_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|req_ready) |=> rsp_valid);

   assert_no_rsp_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(|req_ready) |=> !rsp_valid);

   assert_quiet_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit && rsp_bus == 2'b00) |-> $past(!mem_rd_en && mem_wr_en == 2'b00));

   assert_share_writeback_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_c2c && rsp_bus == 2'b01) |-> $past(mem_wr_en[1] && !mem_rd_en));

   assert_legal_pairs_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !pair_bad);

   assert_no_bad_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !err_state);
endmodule

bind msi_snoop_ctrl msi_snoop_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W)) chk_i (.*);

// File: tb/msi_snoop_ctrl_tb_top.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_tb_top;
   localparam int IDX_W  = 2;
   localparam int TAG_W  = 2;
   localparam int DATA_W = 8;
   localparam int NL     = 1 << IDX_W;
   localparam int NA     = 1 << (TAG_W + IDX_W);
   localparam int AW     = TAG_W + IDX_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [1:0] rv = '0, rw = '0;
   logic [IDX_W-1:0]  ri [2];
   logic [TAG_W-1:0]  rt [2];
   logic [DATA_W-1:0] rd [2];
   logic [1:0]              req_ready, mem_wr_en, rsp_bus;
   logic                    mem_rd_en, rsp_valid, rsp_core, rsp_hit, rsp_c2c, err_state;
   logic [AW-1:0]           mem_rd_addr;
   logic [DATA_W-1:0]       mem_rdata, rsp_rdata;
   logic [2*AW-1:0]         mem_wr_addr;
   logic [2*DATA_W-1:0]     mem_wr_data;

   logic [DATA_W-1:0] bmem [NA];
   logic [DATA_W-1:0] gold [NA];
   int mst  [2][NL];
   int mtag [2][NL];
   int nchk = 0, nfail = 0, last_gnt = 1;
   int e_hit, e_c2c, e_bus, e_rdata;

   msi_snoop_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(rv), .req_write(rw),
      .req_index({ri[1], ri[0]}), .req_tag({rt[1], rt[0]}), .req_wdata({rd[1], rd[0]}),
      .req_ready(req_ready),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rdata(mem_rdata),
      .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_hit(rsp_hit), .rsp_c2c(rsp_c2c),
      .rsp_bus(rsp_bus), .rsp_rdata(rsp_rdata), .err_state(err_state)
   );

   assign mem_rdata = bmem[mem_rd_addr];
   always_ff @(posedge clk) begin
      if (mem_wr_en[0]) bmem[mem_wr_addr[AW-1:0]]    <= mem_wr_data[DATA_W-1:0];
      if (mem_wr_en[1]) bmem[mem_wr_addr[2*AW-1:AW]] <= mem_wr_data[2*DATA_W-1:DATA_W];
   end

   task automatic chk(string rq, string what, int act, int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
      end
   endtask

   // Model from the requirements; checks acceptance-cycle outputs, updates state.
   task automatic predict(int c, string rq);
      int p = 1 - c;
      int idx = int'(ri[c]), tg = int'(rt[c]), wd = int'(rd[c]);
      bit wr = rw[c];
      int addr = tg * NL + idx;
      bit ohit = (mst[c][idx] != 0) && (mtag[c][idx] == tg);
      bit phit = (mst[p][idx] != 0) && (mtag[p][idx] == tg);
      bit powns = phit && (mst[p][idx] == 2);
      bit ev = !ohit && (mst[c][idx] == 2);
      int ev_addr = mtag[c][idx] * NL + idx;
      bit fetch = !wr && !ohit && !powns;
      bit share = !wr && !ohit && powns;
      chk(rq, "ready R2", int'(req_ready), 1 << c);
      chk(rq, "mem_rd_en R3", int'(mem_rd_en), int'(fetch));
      if (fetch) chk(rq, "fetch addr R7", int'(mem_rd_addr), addr);
      chk(rq, "evict en R10", int'(mem_wr_en[0]), int'(ev));
      if (ev) begin
         chk(rq, "evict addr R10", int'(mem_wr_addr[AW-1:0]), ev_addr);
         chk(rq, "evict data R10", int'(mem_wr_data[DATA_W-1:0]), int'(gold[ev_addr]));
      end
      chk(rq, "share wb en R8", int'(mem_wr_en[1]), int'(share));
      if (share) begin
         chk(rq, "share addr R8", int'(mem_wr_addr[2*AW-1:AW]), addr);
         chk(rq, "share data R8", int'(mem_wr_data[2*DATA_W-1:DATA_W]), int'(gold[addr]));
      end
      e_hit = ohit;
      e_c2c = !ohit && powns;
      if (!wr) e_bus = ohit ? 0 : 1;
      else     e_bus = ohit ? ((mst[c][idx] == 1) ? 2 : 0) : 3;
      e_rdata = wr ? wd : int'(gold[addr]);
      if (wr) begin
         gold[addr] = rd[c];
         mst[c][idx] = 2; mtag[c][idx] = tg;
         if (phit) mst[p][idx] = 0;
      end else if (!ohit) begin
         mst[c][idx] = 1; mtag[c][idx] = tg;
         if (powns) mst[p][idx] = 1;
      end
      last_gnt = c;
   endtask

   task automatic check_rsp(int c, string rq);
      chk(rq, "rsp_valid R3", int'(rsp_valid), 1);
      chk(rq, "rsp_core R3", int'(rsp_core), c);
      chk(rq, "rsp_hit", int'(rsp_hit), e_hit);
      chk(rq, "rsp_c2c", int'(rsp_c2c), e_c2c);
      chk(rq, "rsp_bus", int'(rsp_bus), e_bus);
      chk(rq, "rsp_rdata", int'(rsp_rdata), e_rdata);
      chk(rq, "err_state R12", int'(err_state), 0);
   endtask

   task automatic setup(int c, bit wr, int idx, int tg, int wd);
      rw[c] = wr; ri[c] = idx[IDX_W-1:0]; rt[c] = tg[TAG_W-1:0]; rd[c] = wd[DATA_W-1:0];
      rv[c] = 1'b1;
   endtask

   task automatic do_req(int c, bit wr, int idx, int tg, int wd, string rq);
      setup(c, wr, idx, tg, wd);
      #1 predict(c, rq);
      @(posedge clk); #1 rv[c] = 1'b0;
      @(negedge clk); check_rsp(c, rq);
   endtask

   task automatic do_pair(bit w0, int i0, int t0, int d0, bit w1, int i1, int t1, int d1, string rq);
      int first, second;
      setup(0, w0, i0, t0, d0);
      setup(1, w1, i1, t1, d1);
      first = (last_gnt == 0) ? 1 : 0;
      second = 1 - first;
      #1 predict(first, rq);
      @(posedge clk); #1 rv[first] = 1'b0;
      @(negedge clk); check_rsp(first, rq);
      #1 predict(second, rq);
      @(posedge clk); #1 rv[second] = 1'b0;
      @(negedge clk); check_rsp(second, rq);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL R3 watchdog act=%0d exp=%0d", 200000, 0);
      finish_run();
   end

   initial begin
      logic [15:0] lf = 16'hACE1;
      for (int c = 0; c < 2; c++) begin
         ri[c] = '0; rt[c] = '0; rd[c] = '0;
         for (int i = 0; i < NL; i++) begin mst[c][i] = 0; mtag[c][i] = 0; end
      end
      for (int a = 0; a < NA; a++) begin
         bmem[a] = DATA_W'(a * 37 + 5);
         gold[a] = DATA_W'(a * 37 + 5);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);
      chk("R1", "ready idle", int'(req_ready), 0);
      chk("R12", "err after reset", int'(err_state), 0);

      do_req(0, 0, 0, 1, 0,     "R1");   // all Invalid: miss and fetch
      do_req(0, 0, 0, 1, 0,     "R4");   // Shared read hit
      do_req(1, 0, 0, 1, 0,     "R7");   // peer Shared: still fetch
      do_req(1, 1, 0, 1, 8'h5A, "R6");   // Shared write: invalidate
      do_req(1, 1, 0, 1, 8'hC3, "R5");   // Modified write hit
      do_req(1, 0, 0, 1, 0,     "R4");   // Modified read hit
      do_req(0, 0, 0, 1, 0,     "R8");   // peer Modified: cache-to-cache
      do_req(0, 1, 0, 1, 8'h11, "R6");
      do_req(1, 1, 0, 1, 8'h22, "R9");   // write miss, peer Modified
      do_req(0, 1, 2, 3, 8'h33, "R9");   // write miss, no copy anywhere
      do_req(1, 1, 0, 2, 8'h44, "R10");  // replace Modified line
      do_req(1, 0, 0, 1, 0,     "R10");  // evicted word comes back from memory
      do_pair(0, 1, 0, 0, 0, 1, 0, 0, "R2");
      do_pair(0, 3, 1, 0, 1, 3, 2, 8'h77, "R2");
      do_pair(1, 1, 0, 8'h01, 1, 1, 0, 8'h02, "R2");

      for (int n = 0; n < 1500; n++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         if (lf[7:6] == 2'b11)
            do_pair(lf[1], int'(lf[4:3]), int'(lf[6:5]), int'(lf[15:8]),
                    lf[2], int'(lf[4:3]), int'(lf[10:9]), int'(lf[14:7]), "R11");
         else
            do_req(int'(lf[0]), lf[1] & lf[2], int'(lf[4:3]), int'(lf[6:5]),
                   int'(lf[15:8]), "R11");
      end
      finish_run();
   end
endmodule